// File: doc/BRIEF.md
# Ternary Reversible Cascade Synthesizer

This block turns the truth table of a reversible function over m ternary wires (m from 1 to 3) into a list of controlled single-wire ternary gates. Software or a neighbouring block writes the 3^m table rows through a load port while the engine is idle. It then pulses start. The engine walks the table toward the identity mapping and streams out one gate record per correction over a valid/ready channel. Each record carries a target wire, an operator code and two control masks.

The walk is greedy. Row 0 is first forced to all zeros with uncontrolled cyclic shifts. Every later row is then compared, position by position, against the ternary digits of its own index. Each mismatch produces one gate, whose controls come from the nonzero digits of that index. The gate is applied to the stored table by a read-modify-write sweep over every row. After the walk, the engine compares every row with its index and raises an error flag if any row is still wrong. This happens when the input table was not reversible.

Top module: `tss_engine`

## Requirements
- R1: While rst_ni is low, and after its release until a start is accepted, gate_valid_o, busy_o, done_o and error_o are all 0.
- R2: A trit is coded 0, 1 or 2 on two bits, and trit k of a row sits at bits [2k+1:2k]. A write with load_en_i while busy_o is 0 stores load_val_i into row load_row_i. Writes and start pulses while busy_o is 1 are ignored and leave the records and flags of the running job unchanged.
- R3: A start pulse while idle or done raises busy_o in the next cycle. If trit 0 of row 0 is nonzero, gate_valid_o is 1 two cycles after the start pulse.
- R4: For row 0, a trit of value 1 on wire j gives a record with operator 1 (+1) and value 2 gives operator 2 (+2), both with empty control masks. The stored table shifts that position in every row so that row 0's trit becomes 0.
- R5: Rows are visited from 0 to 3^m-1 and positions from 0 to m-1 within a row. The expected trit at position k of row i is digit k of i in base 3, with weight 3^k. At most one record is produced per (row, position), and only where the stored trit differs from the expected one.
- R6: For rows above 0, the operator depends on the stored and expected trits. Stored 1 with expected 0 gives 3 (swap 0/1). Stored 2 with expected 0 gives 4 (swap 0/2). Stored 0 with expected 1 gives 1. Stored 0 with expected 2 gives 2. Stored 2 with expected 1, or stored 1 with expected 2, gives 5 (swap 1/2).
- R7: Bit k of gate_ctl1_o is set exactly when k is not the target and digit k of the row index is 1. gate_ctl2_o is set likewise for digit 2. The two masks never overlap.
- R8: A gate rewrites the target position of every row whose control positions hold the required values. Each row is rewritten from its value before that gate.
- R9: While gate_valid_o is 1 and gate_ready_i is 0, the record stays valid and unchanged and the table is not touched. Every record is delivered exactly once.
- R10: done_o rises after the final row comparison and stays high until the next start. error_o is 1 with done_o exactly when some final row differs from its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Table write strobe |
| load_row_i | input | AW | Row index to write |
| load_val_i | input | 2*M | Row contents, two bits per trit |
| start_i | input | 1 | Start pulse |
| gate_valid_o | output | 1 | Gate record valid |
| gate_ready_i | input | 1 | Consumer accepts record |
| gate_wire_o | output | WW | Target wire |
| gate_op_o | output | 3 | Operator code |
| gate_ctl1_o | output | M | Wires that must hold 1 |
| gate_ctl2_o | output | M | Wires that must hold 2 |
| busy_o | output | 1 | Synthesis in progress |
| done_o | output | 1 | Synthesis finished |
| error_o | output | 1 | Final table is not the identity |

## Verification
busy_o is due one cycle after the start pulse. When row 0 starts with a nonzero trit, the first record is due one cycle after that. The bench checks these two exact cycles at falling edges. Later records do not have fixed cycle times, because each sweep takes 3^m cycles plus any backpressure. So records are compared at every falling edge where valid and ready are both high, in order, against a model of the walk. Error, record count and done persistence are checked once done_o is seen, and again several cycles later.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD1 = 3'd1,
    OP_ADD2 = 3'd2,
    OP_X01  = 3'd3,
    OP_X02  = 3'd4,
    OP_X12  = 3'd5
  } op_e;

  function automatic logic [1:0] op_apply(op_e op, logic [1:0] v);
    logic [1:0] r;
    r = v;
    case (op)
      OP_ADD1: r = (v == 2'd0) ? 2'd1 : (v == 2'd1) ? 2'd2 : (v == 2'd2) ? 2'd0 : v;
      OP_ADD2: r = (v == 2'd0) ? 2'd2 : (v == 2'd1) ? 2'd0 : (v == 2'd2) ? 2'd1 : v;
      OP_X01:  r = (v == 2'd0) ? 2'd1 : (v == 2'd1) ? 2'd0 : v;
      OP_X02:  r = (v == 2'd0) ? 2'd2 : (v == 2'd2) ? 2'd0 : v;
      OP_X12:  r = (v == 2'd1) ? 2'd2 : (v == 2'd2) ? 2'd1 : v;
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic op_e op_pick(logic [1:0] cur, logic [1:0] want);
    op_e r;
    case ({cur, want})
      4'b01_00: r = OP_X01;
      4'b10_00: r = OP_X02;
      4'b00_01: r = OP_ADD1;
      4'b10_01: r = OP_X12;
      4'b00_10: r = OP_ADD2;
      4'b01_10: r = OP_X12;
      default:  r = OP_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tss_table.sv
module tss_table #(
  parameter int unsigned M = 2,
  localparam int unsigned ROWS = 3 ** M,
  localparam int unsigned AW = $clog2(ROWS),
  localparam int unsigned TW = 2 * M
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [TW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [TW-1:0] rdata_o
);

  logic [TW-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i && (waddr_i < AW'(ROWS))) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (raddr_i < AW'(ROWS)) ? mem_q[raddr_i] : '0;

endmodule

// File: rtl/tss_rewrite.sv
module tss_rewrite import tss_pkg::*; #(
  parameter int unsigned M = 2,
  localparam int unsigned TW = 2 * M,
  localparam int unsigned WW = (M > 1) ? $clog2(M) : 1
) (
  input  logic [TW-1:0] row_i,
  input  logic [WW-1:0] tgt_i,
  input  op_e           op_i,
  input  logic [M-1:0]  c1_i,
  input  logic [M-1:0]  c2_i,
  output logic [TW-1:0] row_o
);

  logic [M-1:0] ok;
  logic         hit;

  assign hit = &ok;

  for (genvar k = 0; k < M; k++) begin : g_pos
    logic [1:0] v;
    assign v     = row_i[2*k +: 2];
    assign ok[k] = (!c1_i[k] || v == 2'd1) && (!c2_i[k] || v == 2'd2);
    assign row_o[2*k +: 2] = (hit && tgt_i == WW'(k)) ? op_apply(op_i, v) : v;
  end

endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl import tss_pkg::*; #(
  parameter int unsigned M = 2,
  localparam int unsigned ROWS = 3 ** M,
  localparam int unsigned AW = $clog2(ROWS),
  localparam int unsigned TW = 2 * M,
  localparam int unsigned WW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ready_i,
  input  logic [TW-1:0] rd_row_i,
  output logic [AW-1:0] raddr_o,
  output logic          swp_we_o,
  output logic          valid_o,
  output logic [WW-1:0] wire_o,
  output op_e           rec_op_o,
  output op_e           tbl_op_o,
  output logic [M-1:0]  c1_o,
  output logic [M-1:0]  c2_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_SWEEP, S_CHECK, S_DONE} st_e;

  function automatic logic [TW-1:0] idx_trits(logic [AW-1:0] v);
    logic [TW-1:0] t;
    int unsigned   r;
    r = 32'(v);
    for (int k = 0; k < M; k++) begin
      t[2*k +: 2] = 2'(r % 3);
      r = r / 3;
    end
    return t;
  endfunction

  st_e           st_q, adv_st;
  logic [AW-1:0] row_q, k_q, adv_row;
  logic [WW-1:0] pos_q, adv_pos;
  logic          vld_q, done_q, err_q;
  logic [TW-1:0] p_row, chk_row;
  logic [1:0]    cur, want;
  logic [M-1:0]  c1_n, c2_n;
  logic          last_pos, last_row, last_k, stall;

  assign p_row    = idx_trits(row_q);
  assign chk_row  = idx_trits(k_q);
  assign cur      = rd_row_i[2*int'(pos_q) +: 2];
  assign want     = p_row[2*int'(pos_q) +: 2];
  assign last_pos = (pos_q == WW'(M - 1));
  assign last_row = (row_q == AW'(ROWS - 1));
  assign last_k   = (k_q == AW'(ROWS - 1));
  assign stall    = vld_q & ~ready_i;

  always_comb begin
    for (int k = 0; k < M; k++) begin
      c1_n[k] = (k != int'(pos_q)) && (p_row[2*k +: 2] == 2'd1);
      c2_n[k] = (k != int'(pos_q)) && (p_row[2*k +: 2] == 2'd2);
    end
    adv_pos = last_pos ? '0 : pos_q + 1'b1;
    adv_row = (last_pos && !last_row) ? row_q + 1'b1 : row_q;
    adv_st  = (last_pos && last_row) ? S_CHECK : S_SCAN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      row_q    <= '0;
      pos_q    <= '0;
      k_q      <= '0;
      vld_q    <= 1'b0;
      wire_o   <= '0;
      rec_op_o <= OP_NONE;
      tbl_op_o <= OP_NONE;
      c1_o     <= '0;
      c2_o     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE: begin
          if (start_i) begin
            st_q   <= S_SCAN;
            row_q  <= '0;
            pos_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
          end
        end
        S_SCAN: begin
          if (cur != want) begin
            wire_o <= pos_q;
            c1_o   <= c1_n;
            c2_o   <= c2_n;
            if (row_q == '0) begin
              // record names the shift found; table takes its inverse
              rec_op_o <= (cur == 2'd1) ? OP_ADD1 : OP_ADD2;
              tbl_op_o <= (cur == 2'd1) ? OP_ADD2 : OP_ADD1;
            end else begin
              rec_op_o <= op_pick(cur, want);
              tbl_op_o <= op_pick(cur, want);
            end
            vld_q <= 1'b1;
            k_q   <= '0;
            st_q  <= S_SWEEP;
          end else begin
            pos_q <= adv_pos;
            row_q <= adv_row;
            st_q  <= adv_st;
            k_q   <= '0;
          end
        end
        S_SWEEP: begin
          if (!stall) begin
            if (vld_q) vld_q <= 1'b0;
            if (last_k) begin
              pos_q <= adv_pos;
              row_q <= adv_row;
              st_q  <= adv_st;
              k_q   <= '0;
            end else begin
              k_q <= k_q + 1'b1;
            end
          end
        end
        S_CHECK: begin
          if (rd_row_i != chk_row) err_q <= 1'b1;
          if (last_k) begin
            st_q   <= S_DONE;
            done_q <= 1'b1;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign raddr_o  = (st_q == S_SCAN) ? row_q : k_q;
  assign swp_we_o = (st_q == S_SWEEP) && !stall;
  assign valid_o  = vld_q;
  assign busy_o   = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done_o   = done_q;
  assign error_o  = done_q & err_q;

endmodule

// File: rtl/tss_engine.sv
module tss_engine import tss_pkg::*; #(
  parameter int unsigned M = 2,
  localparam int unsigned ROWS = 3 ** M,
  localparam int unsigned AW = $clog2(ROWS),
  localparam int unsigned TW = 2 * M,
  localparam int unsigned WW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic [AW-1:0] load_row_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          start_i,
  output logic          gate_valid_o,
  input  logic          gate_ready_i,
  output logic [WW-1:0] gate_wire_o,
  output logic [2:0]    gate_op_o,
  output logic [M-1:0]  gate_ctl1_o,
  output logic [M-1:0]  gate_ctl2_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);

  logic [AW-1:0] raddr, waddr;
  logic [TW-1:0] rd_row, new_row, wdata;
  logic          swp_we, we;
  op_e           rec_op, tbl_op;

  tss_ctrl #(.M(M)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ready_i  (gate_ready_i),
    .rd_row_i (rd_row),
    .raddr_o  (raddr),
    .swp_we_o (swp_we),
    .valid_o  (gate_valid_o),
    .wire_o   (gate_wire_o),
    .rec_op_o (rec_op),
    .tbl_op_o (tbl_op),
    .c1_o     (gate_ctl1_o),
    .c2_o     (gate_ctl2_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .error_o  (error_o)
  );

  tss_rewrite #(.M(M)) i_rewrite (
    .row_i (rd_row),
    .tgt_i (gate_wire_o),
    .op_i  (tbl_op),
    .c1_i  (gate_ctl1_o),
    .c2_i  (gate_ctl2_o),
    .row_o (new_row)
  );

  // sweep owns the write port while busy; loads only when idle
  assign we    = swp_we | (load_en_i & ~busy_o);
  assign waddr = swp_we ? raddr : load_row_i;
  assign wdata = swp_we ? new_row : load_val_i;

  tss_table #(.M(M)) i_table (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rd_row)
  );

  assign gate_op_o = rec_op;

endmodule

// File: rtl/tss_engine_chk.sv
module tss_engine_chk #(
  parameter int unsigned M = 2,
  localparam int unsigned WW = (M > 1) ? $clog2(M) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          gate_valid_o,
  input logic          gate_ready_i,
  input logic [WW-1:0] gate_wire_o,
  input logic [2:0]    gate_op_o,
  input logic [M-1:0]  gate_ctl1_o,
  input logic [M-1:0]  gate_ctl2_o,
  input logic          busy_o,
  input logic          done_o
);

  // R9
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_valid_o && !gate_ready_i |=> gate_valid_o);

  // R9
  rec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_valid_o && !gate_ready_i |=> $stable(gate_wire_o) && $stable(gate_op_o)
      && $stable(gate_ctl1_o) && $stable(gate_ctl2_o));

  // R7
  ctl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_valid_o |-> ((gate_ctl1_o & gate_ctl2_o) == '0)
      && !gate_ctl1_o[gate_wire_o] && !gate_ctl2_o[gate_wire_o]);

  // R6
  op_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_valid_o |-> (gate_op_o != 3'd0) && (gate_op_o <= 3'd5));

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  // R5
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_valid_o |-> busy_o);

endmodule

bind tss_engine tss_engine_chk #(.M(M)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .gate_valid_o (gate_valid_o),
  .gate_ready_i (gate_ready_i),
  .gate_wire_o  (gate_wire_o),
  .gate_op_o    (gate_op_o),
  .gate_ctl1_o  (gate_ctl1_o),
  .gate_ctl2_o  (gate_ctl2_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/test_tss_engine.sv
module test_tss_engine;

  localparam int M    = 2;
  localparam int ROWS = 9;
  localparam int AW   = 4;
  localparam int NREC = ROWS * M;
  localparam int NV   = 6;

  // stimulus tables: row r at [4r+3:4r]; expected results come from the model
  localparam logic [35:0] VEC [NV] = '{
    36'hA98654210,  // identity
    36'hA98654120,  // rows 1 and 2 swapped
    36'h8A9465021,  // +1 on trit 0 everywhere
    36'hA08654219,  // rows 0 and 7 swapped
    36'h000000000,  // not reversible
    36'h6184290A5   // scrambled permutation
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_en = 1'b0;
  logic [AW-1:0] load_row = '0;
  logic [3:0]   load_val = '0;
  logic         start = 1'b0;
  logic         ready = 1'b0;
  logic         valid, busy, done, error;
  logic [0:0]   gwire;
  logic [2:0]   gop;
  logic [1:0]   gc1, gc2;

  int n_chk = 0;
  int n_fail = 0;

  int e_wire [NREC];
  int e_op   [NREC];
  int e_c1   [NREC];
  int e_c2   [NREC];
  bit e_r0   [NREC];
  int e_cnt;
  bit e_err;

  always #2 clk = ~clk;

  tss_engine #(.M(M)) i_tss_engine (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_en_i    (load_en),
    .load_row_i   (load_row),
    .load_val_i   (load_val),
    .start_i      (start),
    .gate_valid_o (valid),
    .gate_ready_i (ready),
    .gate_wire_o  (gwire),
    .gate_op_o    (gop),
    .gate_ctl1_o  (gc1),
    .gate_ctl2_o  (gc2),
    .busy_o       (busy),
    .done_o       (done),
    .error_o      (error)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int digit(input int r, input int k);
    return (r / (3 ** k)) % 3;
  endfunction

  function automatic int pick(input int cur, input int want);
    if (want == 0) return (cur == 1) ? 3 : 4;
    if (want == 1) return (cur == 0) ? 1 : 5;
    return (cur == 0) ? 2 : 5;
  endfunction

  function automatic int mapv(input int op, input int v);
    case (op)
      1: return (v + 1) % 3;
      2: return (v + 2) % 3;
      3: return (v == 0) ? 1 : (v == 1) ? 0 : v;
      4: return (v == 0) ? 2 : (v == 2) ? 0 : v;
      5: return (v == 1) ? 2 : (v == 2) ? 1 : v;
      default: return v;
    endcase
  endfunction

  task automatic model(input logic [35:0] t);
    int tb [ROWS][M];
    e_cnt = 0;
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < M; k++) tb[r][k] = int'(t[4*r + 2*k +: 2]);
    for (int i = 0; i < ROWS; i++) begin
      for (int j = 0; j < M; j++) begin
        if (tb[i][j] != digit(i, j)) begin
          int cur, c1, c2, top;
          cur = tb[i][j];
          c1 = 0;
          c2 = 0;
          for (int k = 0; k < M; k++) begin
            if (k != j && digit(i, k) == 1) c1 |= (1 << k);
            if (k != j && digit(i, k) == 2) c2 |= (1 << k);
          end
          e_wire[e_cnt] = j;
          e_c1[e_cnt] = c1;
          e_c2[e_cnt] = c2;
          e_r0[e_cnt] = (i == 0);
          if (i == 0) begin
            e_op[e_cnt] = cur;
            top = (cur == 1) ? 2 : 1;
          end else begin
            e_op[e_cnt] = pick(cur, digit(i, j));
            top = e_op[e_cnt];
          end
          e_cnt++;
          for (int r = 0; r < ROWS; r++) begin
            bit meets;
            meets = 1'b1;
            for (int k = 0; k < M; k++) begin
              if (((c1 >> k) & 1) == 1 && tb[r][k] != 1) meets = 1'b0;
              if (((c2 >> k) & 1) == 1 && tb[r][k] != 2) meets = 1'b0;
            end
            if (meets) tb[r][j] = mapv(top, tb[r][j]);
          end
        end
      end
    end
    e_err = 1'b0;
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < M; k++) if (tb[r][k] != digit(r, k)) e_err = 1'b1;
  endtask

  task automatic load_tbl(input logic [35:0] t);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      load_en  = 1'b1;
      load_row = AW'(r);
      load_val = t[4*r +: 4];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input int mode, input string tag);
    int n;
    int cyc;
    bit fin;
    n = 0;
    cyc = 0;
    fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      ready = (mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (valid && ready) begin
        if (n < e_cnt) begin
          chk(int'(gwire) == e_wire[n], {tag, " R5 target wire"}, int'(gwire), e_wire[n]);
          if (e_r0[n]) chk(int'(gop) == e_op[n], {tag, " R4 row-0 operator"}, int'(gop), e_op[n]);
          else chk(int'(gop) == e_op[n], {tag, " R6 operator"}, int'(gop), e_op[n]);
          chk(int'(gc1) == e_c1[n], {tag, " R7 ctl1 mask"}, int'(gc1), e_c1[n]);
          chk(int'(gc2) == e_c2[n], {tag, " R7 ctl2 mask"}, int'(gc2), e_c2[n]);
        end
        n++;
      end
      if (done) fin = 1'b1;
      if (cyc > 3000) begin
        chk(1'b0, {tag, " R10 done never rose"}, 0, 1);
        fin = 1'b1;
      end
    end
    chk(n == e_cnt, {tag, " R5 R9 record count"}, n, e_cnt);
    chk(error == e_err, {tag, " R8 R10 error flag"}, int'(error), int'(e_err));
    chk(busy == 1'b0, {tag, " R10 busy low at done"}, int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [0:0] s_wire;
    logic [2:0] s_op;
    logic [1:0] s_c1, s_c2;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!valid && !busy && !done && !error, "R1 outputs in reset", int'({valid, busy, done, error}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !busy && !done && !error, "R1 outputs after reset", int'({valid, busy, done, error}), 0);

    // table-driven runs, R2 load path
    for (int v = 0; v < NV; v++) begin
      load_tbl(VEC[v]);
      model(VEC[v]);
      pulse_start();
      collect(0, $sformatf("R2 vec%0d", v));
    end

    // backpressure on the scrambled table
    load_tbl(VEC[5]);
    model(VEC[5]);
    pulse_start();
    collect(1, "R9 throttled");

    // R3 latency and R9 hold under stall
    ready = 1'b0;
    load_tbl(VEC[2]);
    model(VEC[2]);
    pulse_start();
    chk(busy == 1'b1, "R3 busy one cycle after start", int'(busy), 1);
    @(negedge clk);
    chk(valid == 1'b1, "R3 first record two cycles after start", int'(valid), 1);
    s_wire = gwire;
    s_op = gop;
    s_c1 = gc1;
    s_c2 = gc2;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(valid && gwire == s_wire && gop == s_op && gc1 == s_c1 && gc2 == s_c2 && !done,
          "R9 record held while stalled", int'({valid, gop}), int'({1'b1, s_op}));
    end
    collect(0, "R9 after stall");

    // R2 writes and start while busy are ignored
    ready = 1'b0;
    load_tbl(VEC[5]);
    model(VEC[5]);
    pulse_start();
    @(negedge clk);
    load_en = 1'b1;
    load_row = AW'(1);
    load_val = 4'h0;
    start = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    start = 1'b0;
    collect(0, "R2 busy writes");

    // R10 done persists until next start
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R10 done held", int'(done), 1);
    chk(error == e_err, "R10 error held", int'(error), int'(e_err));

    summary();
    $finish;
  end

endmodule